// File: doc/BRIEF.md
# Dual-Channel Center-Aligned PWM Generator

This block is a pulse-width modulation timer with two output pins. A single counter runs in one of two schemes: edge-aligned, where it climbs from zero to a programmed top value and wraps, or center-aligned, where it climbs to the top value and comes back down. One compare value sets the duty cycle in either scheme. A shaper turns the count and the compare value into one base waveform.

An output stage then either copies the base waveform onto both pins, or drives pin 0 with the base waveform and pin 1 with its inverse. In the second case a programmable dead band delays every rising edge, so the two pins are never high together. Each pin has its own enable. The top value, the compare value and the counting scheme are sampled only at a period boundary, so a write made in the middle of a period cannot cut a pulse short. The dead band and the enables act at once.

Top module: `pwm2ch_gen`

## Requirements
- R1: With `ctype_i`=0 (edge-aligned) the count runs 0,1,…,P and then returns to 0, so one output period lasts P+1 clocks, where P is the active top value.
- R2: In edge-aligned counting the base waveform is high for the first C clocks of each period, where C is the active compare value. C=0 gives a constant low, and any C greater than P gives a constant high. With P=4 each step of C adds 20 % duty.
- R3: With `ctype_i`=1 (center-aligned) the count runs 0 up to P and back down to 1, then starts again at 0, so one period lasts 2P clocks. No count value repeats at a turning point.
- R4: In center-aligned counting the base waveform falls at the up-going compare point and rises at the down-going one. The output is high for 2·C of the 2P clocks, and high all period when C≥P. With P=4 each step of C adds 25 %.
- R5: With `omode_i`=0 both pins carry the same base waveform.
- R6: With `omode_i`=1, pin 0 follows the base waveform and pin 1 follows its inverse. Each rising edge on either pin is held back by `dead_i` clocks. A pulse no longer than `dead_i` clocks never appears, and the two pins are never high in the same clock.
- R7: A pin whose enable (`en0_i` or `en1_i`) is 0 stays low.
- R8: New top, compare and counting-scheme values are taken only when a period ends. A pulse already in progress keeps the length set by the old values.
- R9: While `rst_n` is low, and for two clocks after it rises, both pins are low. The first period begins after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| period_i | input | CNT_W | Top value P of the counter |
| cmp_i | input | CNT_W | Compare value C setting the duty |
| ctype_i | input | 1 | 0 = edge-aligned, 1 = center-aligned counting |
| omode_i | input | 1 | 0 = both pins identical, 1 = complementary with dead band |
| dead_i | input | DT_W | Dead-band length in clocks |
| en0_i | input | 1 | Enable for pin 0 |
| en1_i | input | 1 | Enable for pin 1 |
| pwm0_o | output | 1 | PWM pin 0 |
| pwm1_o | output | 1 | PWM pin 1 |

## Verification
The bench sweeps the compare value past both ends of the range in both counting schemes. An off-by-one at the compare point would show as a duty of 1/(P+1) or 1/(2P) off the target, and a wrong clamp would fail to reach 100 %. It checks the period length from one rising edge to the next, which catches a center-aligned counter that lingers at its turning points. It changes the settings while a pulse is high, so a design that applies them at once would cut that pulse short. In complementary mode it uses a dead band longer than the pulse, where a wrong delay would let a short pulse through or let both pins go high together.

// File: rtl/pwm2ch_pkg.sv
`timescale 1ns/1ps
package pwm2ch_pkg;
  typedef enum logic {CT_EDGE = 1'b0, CT_CENTER = 1'b1} ctype_e;
  typedef enum logic {OM_SAME = 1'b0, OM_COMP = 1'b1} omode_e;
endpackage

// File: rtl/pwm2ch_timebase.sv
`timescale 1ns/1ps
module pwm2ch_timebase
  import pwm2ch_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             ctype_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             center_o,
  output logic             falling_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, per_q, per_d, cmp_q, cmp_d;
  logic             up_q, up_d, last;
  ctype_e           ct_q, ct_d;

  // end of the current period
  always_comb begin
    if (ct_q == CT_CENTER)
      last = (!up_q && cnt_q <= ONE) || (up_q && cnt_q >= per_q && per_q <= ONE);
    else
      last = (cnt_q >= per_q);
  end

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    per_d = per_q;
    cmp_d = cmp_q;
    ct_d  = ct_q;
    if (last) begin
      cnt_d = '0;
      up_d  = 1'b1;
      per_d = period_i;
      cmp_d = cmp_i;
      ct_d  = ctype_e'(ctype_i);
    end else if (ct_q == CT_EDGE) begin
      cnt_d = cnt_q + ONE;
    end else if (up_q) begin
      if (cnt_q >= per_q) begin
        cnt_d = cnt_q - ONE;
        up_d  = 1'b0;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      per_q <= '0;
      cmp_q <= '0;
      ct_q  <= CT_EDGE;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
      per_q <= per_d;
      cmp_q <= cmp_d;
      ct_q  <= ct_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign cmp_o     = cmp_q;
  assign center_o  = (ct_q == CT_CENTER);
  assign falling_o = !(up_q && cnt_q < per_q);

  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_q || cnt_q == '0);
  // R3: center-aligned count never repeats a value
  a_r3_center_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (ct_q == CT_CENTER && per_q != '0) |=> cnt_q != $past(cnt_q));
  // R8: the top value changes only while entering count zero
  a_r8_top_held: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0 |-> per_q == $past(per_q));
endmodule

// File: rtl/pwm2ch_shaper.sv
`timescale 1ns/1ps
module pwm2ch_shaper #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             center_i,
  input  logic             falling_i,
  output logic             wave_o
);
  logic wave_q, wave_d;

  always_comb begin
    if (center_i && falling_i) wave_d = (cnt_i <= cmp_i);
    else                       wave_d = (cnt_i <  cmp_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

  assign wave_o = wave_q;

  // R2: a zero compare value never produces a high level in edge-aligned mode
  a_r2_zero_cmp_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!center_i && cmp_i == '0) |=> !wave_q);
endmodule

// File: rtl/pwm2ch_deadband.sv
`timescale 1ns/1ps
module pwm2ch_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            y_o
);
  localparam logic [DT_W-1:0] RUN_MAX = {DT_W{1'b1}};

  logic [DT_W-1:0] run_q, run_d;

  // run_q counts the clocks the source has already been high
  always_comb begin
    if (!s_i)                 run_d = '0;
    else if (run_q == RUN_MAX) run_d = run_q;
    else                      run_d = run_q + DT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign y_o = s_i && (run_q >= dt_i);

  a_r6_rise_held_back: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_i != '0 && $rose(s_i)) |-> !y_o);
endmodule

// File: rtl/pwm2ch_gen.sv
`timescale 1ns/1ps
module pwm2ch_gen
  import pwm2ch_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             ctype_i,
  input  logic             omode_i,
  input  logic [DT_W-1:0]  dead_i,
  input  logic             en0_i,
  input  logic             en1_i,
  output logic             pwm0_o,
  output logic             pwm1_o
);
  localparam int NCH = 2;

  logic [1:0]       rs_q;
  logic             rst_i;
  logic [CNT_W-1:0] cnt, cmp_act;
  logic             center, falling, wave;
  logic [NCH-1:0]   src, dly, en, pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  pwm2ch_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_i), .period_i(period_i), .cmp_i(cmp_i),
    .ctype_i(ctype_i), .cnt_o(cnt), .cmp_o(cmp_act),
    .center_o(center), .falling_o(falling));

  pwm2ch_shaper #(.CNT_W(CNT_W)) u_sh (
    .clk(clk), .rst_n(rst_i), .cnt_i(cnt), .cmp_i(cmp_act),
    .center_i(center), .falling_i(falling), .wave_o(wave));

  assign src = {~wave, wave};
  assign en  = {en1_i, en0_i};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm2ch_deadband #(.DT_W(DT_W)) u_db (
      .clk(clk), .rst_n(rst_i), .s_i(src[g]), .dt_i(dead_i), .y_o(dly[g]));
    assign pin[g] = rst_i && en[g] &&
                    ((omode_e'(omode_i) == OM_COMP) ? dly[g] : wave);
  end

  assign pwm0_o = pin[0];
  assign pwm1_o = pin[1];

  a_r6_never_both: assert property (@(posedge clk) disable iff (!rst_i)
    omode_i |-> !(pwm0_o && pwm1_o));
  a_r5_same_pins: assert property (@(posedge clk) disable iff (!rst_i)
    (!omode_i && en0_i && en1_i) |-> pwm0_o == pwm1_o);
endmodule

// File: tb/pwm2ch_gen_tb_top.sv
`timescale 1ns/1ps
module pwm2ch_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] period_i, cmp_i;
  logic        ctype_i, omode_i, en0_i, en1_i;
  logic [7:0]  dead_i;
  logic        pwm0_o, pwm1_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit chk_en = 0;
  string cur_req = "R5";

  always #2.5 clk = ~clk;

  pwm2ch_gen dut_i (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .cmp_i(cmp_i),
    .ctype_i(ctype_i), .omode_i(omode_i), .dead_i(dead_i),
    .en0_i(en0_i), .en1_i(en1_i), .pwm0_o(pwm0_o), .pwm1_o(pwm1_o));

  // behavioural reference: position within the period
  int m_pos, m_per, m_cmp, m_run0, m_run1;
  bit m_ud, m_wave, r1, r2;

  function automatic int plen();
    if (m_ud) return (2 * m_per < 1) ? 1 : 2 * m_per;
    return m_per + 1;
  endfunction

  function automatic bit mbase();
    if (m_ud) return (m_pos < m_cmp) || (m_pos >= 2 * m_per - m_cmp);
    return m_pos < m_cmp;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1 = 0; r2 = 0; m_pos = 0; m_per = 0; m_cmp = 0; m_ud = 0;
      m_wave = 0; m_run0 = 0; m_run1 = 0;
    end else begin
      if (r2) begin
        bit nb;
        nb = mbase();
        m_run0 = m_wave  ? ((m_run0 + 1 > 255) ? 255 : m_run0 + 1) : 0;
        m_run1 = !m_wave ? ((m_run1 + 1 > 255) ? 255 : m_run1 + 1) : 0;
        m_wave = nb;
        if (m_pos == plen() - 1) begin
          m_pos = 0; m_per = int'(period_i); m_cmp = int'(cmp_i); m_ud = ctype_i;
        end else m_pos++;
      end
      r2 = r1; r1 = 1;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_en) begin
      bit e0, e1, d0, d1;
      d0 = m_wave && (m_run0 >= int'(dead_i));
      d1 = !m_wave && (m_run1 >= int'(dead_i));
      e0 = r2 && en0_i && (omode_i ? d0 : m_wave);
      e1 = r2 && en1_i && (omode_i ? d1 : m_wave);
      checks++;
      if (pwm0_o !== e0 || pwm1_o !== e1) begin
        errors++;
        $display("FAIL %s model: pins=%b%b expected=%b%b", cur_req, pwm1_o, pwm0_o, e1, e0);
      end
    end
  end

  task automatic setup(input int p, input int c, input bit ud, input bit om,
                       input int dt, input bit e0, input bit e1);
    @(posedge clk); #1;
    period_i = 16'(p); cmp_i = 16'(c); ctype_i = ud; omode_i = om;
    dead_i = 8'(dt); en0_i = e0; en1_i = e1;
  endtask

  task automatic measure(input int n, output int h0, output int h1, output int both);
    h0 = 0; h1 = 0; both = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm0_o) h0++;
      if (pwm1_o) h1++;
      if (pwm0_o && pwm1_o) both++;
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    bit prev;
    prev = 1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (pwm0_o && !prev) break;
      prev = pwm0_o;
    end
  endtask

  task automatic rise_spacing(output int sp);
    wait_rise();
    sp = 0;
    begin
      bit prev;
      prev = 1;
      for (int i = 0; i < 1000; i++) begin
        @(negedge clk);
        sp++;
        if (pwm0_o && !prev) break;
        prev = pwm0_o;
      end
    end
  endtask

  initial begin
    int h0, h1, bo, sp;
    rst_n = 0;
    period_i = 16'd4; cmp_i = 16'd2; ctype_i = 0; omode_i = 0;
    dead_i = 0; en0_i = 1; en1_i = 1;
    repeat (3) @(negedge clk);
    check("R9 reset pin0", pwm0_o, 0);
    check("R9 reset pin1", pwm1_o, 0);
    @(posedge clk); #1 rst_n = 1;
    chk_en = 1;
    cur_req = "R9";
    @(negedge clk);
    check("R9 after release", pwm0_o, 0);

    cur_req = "R2";
    for (int c = 0; c <= 6; c++) begin
      setup(4, c, 0, 0, 0, 1, 1);
      repeat (14) @(posedge clk);
      measure(10, h0, h1, bo);
      check("R2 edge duty", h0, 2 * ((c > 5) ? 5 : c));
      check("R5 same pins", h1, h0);
    end

    cur_req = "R4";
    for (int c = 0; c <= 5; c++) begin
      setup(4, c, 1, 0, 0, 1, 1);
      repeat (20) @(posedge clk);
      measure(16, h0, h1, bo);
      check("R4 center duty", h0, 4 * ((c > 4) ? 4 : c));
    end

    cur_req = "R1";
    setup(7, 3, 0, 0, 0, 1, 1);
    repeat (20) @(posedge clk);
    rise_spacing(sp);
    check("R1 edge period", sp, 8);

    cur_req = "R3";
    setup(5, 2, 1, 0, 0, 1, 1);
    repeat (25) @(posedge clk);
    rise_spacing(sp);
    check("R3 center period", sp, 10);
    measure(20, h0, h1, bo);
    check("R3 center high time", h0, 8);

    cur_req = "R6";
    setup(9, 5, 1, 1, 2, 1, 1);
    repeat (40) @(posedge clk);
    measure(36, h0, h1, bo);
    check("R6 pin0 delayed", h0, 16);
    check("R6 pin1 delayed", h1, 12);
    check("R6 no overlap", bo, 0);
    setup(9, 2, 0, 1, 3, 1, 1);
    repeat (25) @(posedge clk);
    measure(20, h0, h1, bo);
    check("R6 short pulse swallowed", h0, 0);
    check("R6 inverse pin", h1, 10);

    cur_req = "R7";
    setup(4, 3, 0, 0, 0, 0, 1);
    repeat (14) @(posedge clk);
    measure(10, h0, h1, bo);
    check("R7 disabled pin0", h0, 0);
    check("R7 enabled pin1", h1, 6);
    setup(4, 3, 0, 1, 1, 1, 0);
    repeat (14) @(posedge clk);
    measure(10, h0, h1, bo);
    check("R7 disabled pin1", h1, 0);

    cur_req = "R8";
    setup(9, 5, 0, 0, 0, 1, 1);
    repeat (25) @(posedge clk);
    wait_rise();
    begin
      int hl;
      hl = 1;
      @(posedge clk); #1;
      cmp_i = 16'd9; period_i = 16'd4; ctype_i = 1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (pwm0_o) hl++; else break;
      end
      check("R8 pulse keeps old length", hl, 5);
    end
    repeat (10) @(posedge clk);
    measure(8, h0, h1, bo);
    check("R8 new settings full duty", h0, 8);

    chk_en = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule